// File: doc/BRIEF.md
# Cycle-Stealing Peripheral Event Transfer Engine

The engine answers interrupt requests that are routed to it without running an interrupt routine. It has eight channels. For a routed request it makes one data move on the memory bus: one read from a source address and one write to a destination address. Each channel has its own source pointer, destination pointer, transfer counter and control field. After each move, the channel's pointers and counter are updated as its control field says. When a channel's counter has run down to zero, the next request on that channel is not served with a move. It is passed on as a one-cycle interrupt pulse on that channel's interrupt output, so the CPU can run its normal handler. A channel in continuous mode ignores its counter and never produces the interrupt.

Software sets up a channel through a write-only port that selects the channel, the register and the data. The engine asks for the bus with `bus_req_o` and waits for `bus_gnt_i`. It then drives one read cycle and one write cycle and gives the bus back.

The controller has five states. IDLE picks the lowest pending channel. From IDLE it goes to WAIT when a move is due, or to INTR when the channel's counter is exhausted. WAIT holds the bus request and moves to READ in the cycle after a grant is seen. READ drives the source address and captures the read data, then always moves to WRITE. WRITE drives the destination address and data, updates the channel, and returns to IDLE. INTR pulses the channel's interrupt for one cycle and returns to IDLE.

Top module: `pdt_engine`

## Requirements
- R1: After reset, `bus_req_o`, `mem_rd_o`, `mem_wr_o` and all of `irq_o` are 0, and every channel register is 0.
- R2: A one-cycle pulse on `req_i[n]` stays pending until channel n is served. When several channels are pending, the lowest channel number is served first.
- R3: Before a read, `bus_req_o` is high and the engine waits in WAIT for as long as `bus_gnt_i` is low. `mem_rd_o` rises only in the cycle after `bus_gnt_i` was sampled high.
- R4: A move is one `mem_rd_o` cycle at the source pointer, followed in the very next cycle by one `mem_wr_o` cycle at the destination pointer carrying the data read. When control bit 0 is 1 the move is a word. When it is 0 the move is a byte: `mem_byte_o` is 1 in both cycles and the written data is the low read byte, zero-extended.
- R5: When control bit 1 is 1, the source pointer advances after each move by 2 for a word or by 1 for a byte. When it is 0, the source pointer is left unchanged.
- R6: When control bit 2 is 1, the destination pointer advances after each move by 2 for a word or by 1 for a byte. When it is 0, the destination pointer is left unchanged.
- R7: When control bit 3 is 0, each move decrements the counter by one. A request that finds the counter at zero makes no bus access and instead gives one interrupt pulse on the requesting channel.
- R8: When control bit 3 is 1 (continuous mode), the counter is not changed and not examined. Every request is served with a move, even with the counter at zero, and no interrupt is raised.
- R9: A configuration write (`cfg_we`=1) loads the register chosen by `cfg_sel` of channel `cfg_ch`: 0 is the source pointer, 1 the destination pointer, 2 the counter (low bits), and 3 the control field (bits 3..0).
- R10: `irq_o` has at most one bit set, and each interrupt pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel selected for configuration |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 counter, 3 control |
| cfg_wdata | input | 16 | Configuration write data |
| req_i | input | 8 | Routed request pulses, one per channel |
| bus_req_o | output | 1 | Bus request to the CPU arbiter |
| bus_gnt_i | input | 1 | Bus grant from the CPU arbiter |
| mem_addr_o | output | 16 | Memory byte address |
| mem_rd_o | output | 1 | Read strobe; data is sampled at the end of the cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_byte_o | output | 1 | 1 for a byte access, 0 for a word access |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid during a read cycle |
| irq_o | output | 8 | Interrupt pulse per channel when the counter is exhausted |

## Verification
The move is tried in several shapes: word moves with both pointers advancing, byte moves with only the source advancing, and byte moves with only the destination advancing. Each shape separates the step size from the choice of pointer, and a wrong step or a wrong pointer shows up on the next address.

A counter loaded with 1 separates the move that uses it up from the request that must become an interrupt. Continuous mode with the counter at zero shows that the counter is not examined. Three requests pulsed together in non-ascending order show the service order.

A held-off grant shows that no read leaks out before the bus is granted. Every read, write and interrupt is compared in order against a queue predicted from a model of the channels and of memory.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_INTR
    } pdt_state_e;

    // bit0 word, bit1 advance source, bit2 advance destination, bit3 continuous
    typedef struct packed {
        logic cont;
        logic inc_dst;
        logic inc_src;
        logic word;
    } pdt_ctl_t;

    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

endpackage

// File: rtl/pdt_chan_regs.sv
module pdt_chan_regs
    import pdt_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int CW  = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic           upd_en,
    input  logic [CHW-1:0] upd_ch,
    output logic [AW-1:0]  src_o [NCH],
    output logic [AW-1:0]  dst_o [NCH],
    output logic [CW-1:0]  cnt_o [NCH],
    output pdt_ctl_t       ctl_o [NCH]
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic           cfg_hit;
        logic           upd_hit;
        logic [AW-1:0]  step;

        assign cfg_hit = cfg_we && (cfg_ch == CHW'(g));
        assign upd_hit = upd_en && (upd_ch == CHW'(g)) && !cfg_hit;
        assign step    = ctl_o[g].word ? AW'(2) : AW'(1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_o[g] <= '0;
                dst_o[g] <= '0;
                cnt_o[g] <= '0;
                ctl_o[g] <= '0;
            end else if (cfg_hit) begin
                unique case (cfg_sel)
                    SEL_SRC: src_o[g] <= cfg_wdata;
                    SEL_DST: dst_o[g] <= cfg_wdata;
                    SEL_CNT: cnt_o[g] <= cfg_wdata[CW-1:0];
                    SEL_CTL: ctl_o[g] <= pdt_ctl_t'(cfg_wdata[3:0]);
                    default: ;
                endcase
            end else if (upd_hit) begin
                if (ctl_o[g].inc_src) src_o[g] <= src_o[g] + step;
                if (ctl_o[g].inc_dst) dst_o[g] <= dst_o[g] + step;
                if (!ctl_o[g].cont && cnt_o[g] != '0) cnt_o[g] <= cnt_o[g] - 1'b1;
            end
        end

        p_cnt_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_hit && !ctl_o[g].cont && cnt_o[g] != '0) |=> cnt_o[g] == $past(cnt_o[g]) - 1'b1);

        p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_hit && ctl_o[g].cont) |=> $stable(cnt_o[g]));

        p_src_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_hit && ctl_o[g].inc_src) |=>
            src_o[g] == $past(src_o[g]) + ($past(ctl_o[g].word) ? AW'(2) : AW'(1)));

        p_dst_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_hit && ctl_o[g].inc_dst) |=>
            dst_o[g] == $past(dst_o[g]) + ($past(ctl_o[g].word) ? AW'(2) : AW'(1)));
    end

endmodule

// File: rtl/pdt_pick.sv
module pdt_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend_i,
    output logic          vld_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                vld_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/pdt_engine.sv
module pdt_engine
    import pdt_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic [NCH-1:0] req_i,
    output logic           bus_req_o,
    input  logic           bus_gnt_i,
    output logic [AW-1:0]  mem_addr_o,
    output logic           mem_rd_o,
    output logic           mem_wr_o,
    output logic           mem_byte_o,
    output logic [DW-1:0]  mem_wdata_o,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic [NCH-1:0] irq_o
);

    pdt_state_e     state, nxt;
    logic [NCH-1:0] pend;
    logic [CHW-1:0] cur;
    logic [DW-1:0]  data_q;
    logic           pick_vld;
    logic [CHW-1:0] pick_idx;
    logic           take;
    logic           upd_en;
    logic           zero_hit;

    logic [AW-1:0]  src [NCH];
    logic [AW-1:0]  dst [NCH];
    logic [CW-1:0]  cnt [NCH];
    pdt_ctl_t       ctl [NCH];

    pdt_chan_regs #(.NCH(NCH), .AW(AW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .upd_en    (upd_en),
        .upd_ch    (cur),
        .src_o     (src),
        .dst_o     (dst),
        .cnt_o     (cnt),
        .ctl_o     (ctl)
    );

    pdt_pick #(.N(NCH)) u_pick (
        .pend_i (pend),
        .vld_o  (pick_vld),
        .idx_o  (pick_idx)
    );

    assign zero_hit    = (cnt[pick_idx] == '0) && !ctl[pick_idx].cont;
    assign mem_wdata_o = data_q;

    // state register, pending latches, channel and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend   <= '0;
            cur    <= '0;
            data_q <= '0;
        end else begin
            state <= nxt;
            pend  <= (pend & ~(take ? (NCH'(1) << pick_idx) : '0)) | req_i;
            if (take) cur <= pick_idx;
            if (state == ST_READ)
                data_q <= ctl[cur].word ? mem_rdata_i : DW'(mem_rdata_i[7:0]);
        end
    end

    // next state and outputs
    always_comb begin
        nxt        = state;
        take       = 1'b0;
        upd_en     = 1'b0;
        bus_req_o  = 1'b0;
        mem_rd_o   = 1'b0;
        mem_wr_o   = 1'b0;
        mem_byte_o = 1'b0;
        mem_addr_o = '0;
        irq_o      = '0;
        unique case (state)
            ST_IDLE: begin
                if (pick_vld) begin
                    take = 1'b1;
                    nxt  = zero_hit ? ST_INTR : ST_WAIT;
                end
            end
            ST_WAIT: begin
                bus_req_o = 1'b1;
                if (bus_gnt_i) nxt = ST_READ;
            end
            ST_READ: begin
                bus_req_o  = 1'b1;
                mem_rd_o   = 1'b1;
                mem_byte_o = !ctl[cur].word;
                mem_addr_o = src[cur];
                nxt        = ST_WRITE;
            end
            ST_WRITE: begin
                bus_req_o  = 1'b1;
                mem_wr_o   = 1'b1;
                mem_byte_o = !ctl[cur].word;
                mem_addr_o = dst[cur];
                upd_en     = 1'b1;
                nxt        = ST_IDLE;
            end
            ST_INTR: begin
                irq_o[cur] = 1'b1;
                nxt        = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    p_lowest_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |-> (pend[pick_idx] && ((pend & ((NCH'(1) << pick_idx) - NCH'(1))) == '0)));

    p_read_after_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_o) |-> $past(bus_gnt_i) && $past(bus_req_o));

    p_write_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> mem_wr_o && !mem_rd_o);

    p_irq_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> !bus_req_o && !mem_rd_o && !mem_wr_o);

    p_irq_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |=> (irq_o == '0));

endmodule

// File: tb/sim_pdt_engine.sv
`timescale 1ns/1ps
module sim_pdt_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [7:0]  req_i = '0;
    logic        bus_req_o;
    logic        bus_gnt_i = 1'b0;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o, mem_wr_o, mem_byte_o;
    logic [15:0] mem_wdata_o;
    logic [15:0] mem_rdata_i;
    logic [7:0]  irq_o;

    int checks = 0;
    int errors = 0;
    logic hold = 1'b0;

    always #2.5 clk = ~clk;

    pdt_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_i(req_i), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
        .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_byte_o(mem_byte_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .irq_o(irq_o)
    );

    // memory the engine sees, and a shadow used for predictions
    logic [7:0] mem [256];
    logic [7:0] sh  [256];
    assign mem_rdata_i = {mem[8'(mem_addr_o[7:0] + 8'd1)], mem[mem_addr_o[7:0]]};

    always @(posedge clk) begin
        if (mem_wr_o) begin
            mem[mem_addr_o[7:0]] <= mem_wdata_o[7:0];
            if (!mem_byte_o) mem[8'(mem_addr_o[7:0] + 8'd1)] <= mem_wdata_o[15:8];
        end
    end

    always @(negedge clk) bus_gnt_i <= bus_req_o && !hold;

    // channel model
    logic [15:0] m_src [8];
    logic [15:0] m_dst [8];
    logic [7:0]  m_cnt [8];
    logic [3:0]  m_ctl [8];

    typedef struct packed {
        logic [1:0]  kind;   // 0 read, 1 write, 2 interrupt
        logic [15:0] addr;
        logic [15:0] data;
        logic        byt;
        logic [3:0]  rq;
    } exp_t;
    exp_t sb [$];

    task automatic fail_line(input int rq, input string what, input logic [31:0] act, input logic [31:0] expv);
        errors++;
        $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, expv);
    endtask

    task automatic cfg(input int ch, input int sel, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: m_src[ch] = v;
            1: m_dst[ch] = v;
            2: m_cnt[ch] = v[7:0];
            default: m_ctl[ch] = v[3:0];
        endcase
    endtask

    task automatic setup(input int ch, input logic [15:0] s, input logic [15:0] d,
                         input logic [7:0] c, input logic [3:0] k);
        cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, {8'h00, c}); cfg(ch, 3, {12'h000, k});
    endtask

    task automatic predict(input int ch, input int rq);
        exp_t e;
        logic [7:0] a, b;
        logic [15:0] dat;
        logic wd;
        if (!m_ctl[ch][3] && m_cnt[ch] == 8'd0) begin
            e = '{kind: 2'd2, addr: 16'(1 << ch), data: 16'h0, byt: 1'b0, rq: 4'(rq)};
            sb.push_back(e);
            return;
        end
        wd = m_ctl[ch][0];
        a = m_src[ch][7:0];
        b = m_dst[ch][7:0];
        dat = wd ? {sh[8'(a + 8'd1)], sh[a]} : {8'h00, sh[a]};
        e = '{kind: 2'd0, addr: m_src[ch], data: 16'h0, byt: !wd, rq: 4'(rq)};
        sb.push_back(e);
        e = '{kind: 2'd1, addr: m_dst[ch], data: dat, byt: !wd, rq: 4'(rq)};
        sb.push_back(e);
        sh[b] = dat[7:0];
        if (wd) sh[8'(b + 8'd1)] = dat[15:8];
        if (m_ctl[ch][1]) m_src[ch] = m_src[ch] + (wd ? 16'd2 : 16'd1);
        if (m_ctl[ch][2]) m_dst[ch] = m_dst[ch] + (wd ? 16'd2 : 16'd1);
        if (!m_ctl[ch][3]) m_cnt[ch] = m_cnt[ch] - 8'd1;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk); req_i = m;
        @(negedge clk); req_i = '0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && sb.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic serve(input int ch, input int rq);
        predict(ch, rq);
        pulse(8'(1 << ch));
        drain();
    endtask

    task automatic observe(input logic [1:0] kind, input logic [15:0] addr,
                           input logic [15:0] data, input logic byt);
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
            fail_line(2, "unexpected bus or interrupt event", {14'h0, kind, addr}, 32'h0);
            return;
        end
        e = sb.pop_front();
        if (e.kind != kind || e.addr != addr || e.byt != byt || (kind == 2'd1 && e.data != data))
            fail_line(int'(e.rq), "event mismatch kind/addr/data/byte",
                      {kind, byt, 13'h0, addr[7:0], data[7:0]},
                      {e.kind, e.byt, 13'h0, e.addr[7:0], e.data[7:0]});
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_o) observe(2'd0, mem_addr_o, 16'h0, mem_byte_o);
            if (mem_wr_o) observe(2'd1, mem_addr_o, mem_wdata_o, mem_byte_o);
            if (|irq_o)   observe(2'd2, {8'h00, irq_o}, 16'h0, 1'b0);
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            sh[i]  = 8'(i * 7 + 3);
        end
        for (int i = 0; i < 8; i++) begin
            m_src[i] = '0; m_dst[i] = '0; m_cnt[i] = '0; m_ctl[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        checks++;
        if (bus_req_o || mem_rd_o || mem_wr_o || irq_o != '0)
            fail_line(1, "outputs after reset", {bus_req_o, mem_rd_o, mem_wr_o, irq_o}, 32'h0);

        // R9 R4 R5 R6: word moves, both pointers advance
        setup(0, 16'h0010, 16'h0080, 8'd3, 4'b0111);
        serve(0, 4);
        serve(0, 5);

        // R4 R5: byte moves, only the source advances
        setup(1, 16'h0021, 16'h0090, 8'd4, 4'b0010);
        serve(1, 5);
        serve(1, 4);

        // R6: byte moves, only the destination advances
        setup(2, 16'h0030, 16'h00A1, 8'd4, 4'b0100);
        serve(2, 6);
        serve(2, 6);

        // R7: counter of 1, one move, then interrupts only
        setup(3, 16'h0040, 16'h00B0, 8'd1, 4'b0011);
        serve(3, 7);
        serve(3, 7);
        serve(3, 10);

        // R8: continuous mode with counter at zero keeps moving, no interrupt
        setup(4, 16'h0050, 16'h00C0, 8'd0, 4'b1111);
        serve(4, 8);
        serve(4, 8);
        serve(4, 8);

        // R2: three channels pulsed together, lowest served first
        setup(5, 16'h0060, 16'h00D0, 8'd2, 4'b0001);
        setup(6, 16'h0068, 16'h00E0, 8'd2, 4'b0001);
        setup(7, 16'h0070, 16'h00F0, 8'd2, 4'b0000);
        predict(5, 2); predict(6, 2); predict(7, 2);
        pulse(8'b1110_0000);
        drain();

        // R3: grant held off, no read until granted
        hold = 1'b1;
        predict(6, 3);
        pulse(8'b0100_0000);
        repeat (6) @(negedge clk);
        checks++;
        if (!bus_req_o) fail_line(3, "bus_req_o while waiting", {31'h0, bus_req_o}, 32'h1);
        checks++;
        if (mem_rd_o || mem_wr_o) fail_line(3, "bus access before grant", {30'h0, mem_rd_o, mem_wr_o}, 32'h0);
        hold = 1'b0;
        drain();

        // R7 R10: channel 6 exhausted now, interrupt pulse
        serve(6, 10);

        checks++;
        if (sb.size() != 0) fail_line(2, "events still expected", 32'(sb.size()), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule